// File: doc/BRIEF.md
# ADC Code Histogram Collector

This block builds an occurrence histogram of raw converter output codes during a characterization run. It keeps no raw samples. It keeps one counter per code bin in on-chip RAM. Each accepted sample adds one to the counter of its code. Each counter saturates at its maximum value and never wraps. A sticky flag records that a counter saturated. A 2-stage read-modify-write pipeline accepts one sample per cycle. When back-to-back samples fall in the same bin, the pipeline forwards the pending value to the second sample.

A start command first sweeps every bin to zero, one address per cycle, and then opens collection. A stop command closes collection. The block also tracks the total number of accepted samples and the lowest and highest codes that were hit. These are the two end bins that a later sine-fit step uses to estimate amplitude and offset.

A read command then streams every bin in ascending order over a valid/ready channel. Each beat carries the bin index, the count, and the running cumulative count. The final beat is flagged. A downstream processor normalizes the cumulative count by the total.

Top module: `adc_code_hist`

## Requirements
- R1: A start (accepted when idle or collecting) raises `busy_o` for exactly 2^CODE_W cycles while every bin is written to zero. In the same step it zeroes `total_o` and `ovf_o`. After reset, `busy_o`, `ovf_o`, `range_vld_o` and `rd_vld_o` are 0 and `total_o` is 0.
- R2: A sample is ignored, with no effect on any bin or on `total_o`, in each of these cases:
  - it arrives while `busy_o` is high;
  - it arrives outside collection (before the first start, after stop, or during a readout);
  - it arrives in the same cycle as a start or a stop.
- R3: Every accepted sample adds one to the bin equal to its code. This holds for consecutive samples to the same bin in back-to-back cycles.
- R4: `total_o` equals the number of accepted samples since the last start. It updates two cycles after a sample is accepted.
- R5: A bin counter never wraps. It holds at 2^CNT_W-1. A sample landing on a full bin sets `ovf_o`, which stays high until the next start.
- R6: `lo_bin_o` and `hi_bin_o` are the minimum and maximum accepted codes. `range_vld_o` is 1 only when the block is idle or reading and at least one sample was accepted since the last start. It is 0 while clearing or collecting.
- R7: A read command is accepted only when idle. It streams bins 0 to 2^CODE_W-1 in ascending order, one per valid/ready handshake. Each beat's `rd_bin_o` is the bin index and `rd_cnt_o` is that bin's count. A read command at any other time produces no beat.
- R8: `rd_cum_o` equals the sum of the counts of bins 0 through `rd_bin_o`. `rd_last_o` is 1 only on bin 2^CODE_W-1. When no bin saturated, the cumulative count on that beat equals `total_o`.
- R9: While `rd_vld_o` is 1 and `rd_rdy_i` is 0, `rd_vld_o` stays 1 and the beat fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear all bins, then begin collection |
| stop_i | input | 1 | End collection |
| read_i | input | 1 | Begin a readout pass (idle only) |
| smp_vld_i | input | 1 | Sample strobe |
| smp_code_i | input | CODE_W | Raw converter code |
| busy_o | output | 1 | Clear sweep in progress |
| ovf_o | output | 1 | Sticky: a bin counter saturated |
| total_o | output | TOT_W | Accepted sample count |
| range_vld_o | output | 1 | Lowest/highest bin outputs are meaningful |
| lo_bin_o | output | CODE_W | Lowest non-empty bin |
| hi_bin_o | output | CODE_W | Highest non-empty bin |
| rd_vld_o | output | 1 | Readout beat valid |
| rd_rdy_i | input | 1 | Readout beat accepted |
| rd_bin_o | output | CODE_W | Bin index of beat |
| rd_cnt_o | output | CNT_W | Count of that bin |
| rd_cum_o | output | TOT_W | Cumulative count through that bin |
| rd_last_o | output | 1 | Final bin of the pass |

## Verification
The hardest case to reach from the ports is a sample that arrives while the previous sample to the same bin is still being written. Only same-code samples in consecutive cycles exercise the forwarding path, so random codes alone rarely hit it. The stimulus mixes random codes drawn from a narrow band with directed same-code bursts. Saturation needs a long run on a single bin, so the bench shrinks the counter width and then drives one code back-to-back past full scale.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COLLECT,
    ST_READ
  } hist_st_e;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_FETCH,
    RD_SHOW
  } rd_st_e;
endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // read returns the value before a same-edge write
  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/hist_rmw.sv
module hist_rmw #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  rdata_i,
  output logic              we_o,
  output logic [CODE_W-1:0] waddr_o,
  output logic [CNT_W-1:0]  wdata_o,
  output logic              sat_o,
  output logic              upd_o,
  output logic [CODE_W-1:0] upd_code_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              s1_vld_q, s2_vld_q;
  logic [CODE_W-1:0] s1_code_q, s2_code_q;
  logic [CNT_W-1:0]  s2_val_q;
  logic              fwd;
  logic              full;
  logic [CNT_W-1:0]  old_val, new_val;

  // s2 holds the value written on the edge that also launched the s1 read
  assign fwd     = s2_vld_q && (s2_code_q == s1_code_q);
  assign old_val = fwd ? s2_val_q : rdata_i;
  assign full    = (old_val == CNT_MAX);
  assign new_val = full ? old_val : old_val + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_code_q <= '0;
      s2_vld_q  <= 1'b0;
      s2_code_q <= '0;
      s2_val_q  <= '0;
    end else begin
      s1_vld_q  <= acc_i;
      s1_code_q <= code_i;
      s2_vld_q  <= s1_vld_q;
      s2_code_q <= s1_code_q;
      s2_val_q  <= new_val;
    end
  end

  assign we_o       = s1_vld_q;
  assign waddr_o    = s1_code_q;
  assign wdata_o    = new_val;
  assign sat_o      = s1_vld_q && full;
  assign upd_o      = s1_vld_q;
  assign upd_code_o = s1_code_q;

  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (wdata_o != '0));
endmodule

// File: rtl/hist_reader.sv
module hist_reader
  import hist_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 24,
  parameter int TOT_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  rdata_i,
  output logic [CODE_W-1:0] raddr_o,
  output logic              done_o,
  output logic              rd_vld_o,
  input  logic              rd_rdy_i,
  output logic [CODE_W-1:0] rd_bin_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [TOT_W-1:0]  rd_cum_o,
  output logic              rd_last_o
);
  localparam logic [CODE_W-1:0] LAST_BIN = '1;

  rd_st_e            st_q;
  logic [CODE_W-1:0] addr_q;
  logic [TOT_W-1:0]  cum_q;
  logic [TOT_W-1:0]  cum_next;
  logic              hs;

  assign cum_next  = cum_q + {{(TOT_W-CNT_W){1'b0}}, rdata_i};
  assign rd_vld_o  = (st_q == RD_SHOW);
  assign hs        = rd_vld_o && rd_rdy_i;
  assign rd_last_o = rd_vld_o && (addr_q == LAST_BIN);
  assign done_o    = hs && rd_last_o;
  assign raddr_o   = addr_q;
  assign rd_bin_o  = addr_q;
  assign rd_cnt_o  = rdata_i;
  assign rd_cum_o  = cum_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RD_IDLE;
      addr_q <= '0;
      cum_q  <= '0;
    end else begin
      unique case (st_q)
        RD_IDLE: if (go_i) begin
          addr_q <= '0;
          cum_q  <= '0;
          st_q   <= RD_FETCH;
        end
        RD_FETCH: st_q <= RD_SHOW;
        RD_SHOW: if (hs) begin
          cum_q <= cum_next;
          if (addr_q == LAST_BIN) begin
            st_q <= RD_IDLE;
          end else begin
            addr_q <= addr_q + 1'b1;
            st_q   <= RD_FETCH;
          end
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  // R9
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vld_o && !rd_rdy_i) |=> (rd_vld_o && $stable(rd_bin_o) &&
                                 $stable(rd_cnt_o) && $stable(rd_cum_o)));
  // R8
  cum_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> (rd_cum_o >= {{(TOT_W-CNT_W){1'b0}}, rd_cnt_o}));
endmodule

// File: rtl/adc_code_hist.sv
module adc_code_hist
  import hist_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 24,
  parameter int TOT_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              read_i,
  input  logic              smp_vld_i,
  input  logic [CODE_W-1:0] smp_code_i,
  output logic              busy_o,
  output logic              ovf_o,
  output logic [TOT_W-1:0]  total_o,
  output logic              range_vld_o,
  output logic [CODE_W-1:0] lo_bin_o,
  output logic [CODE_W-1:0] hi_bin_o,
  output logic              rd_vld_o,
  input  logic              rd_rdy_i,
  output logic [CODE_W-1:0] rd_bin_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [TOT_W-1:0]  rd_cum_o,
  output logic              rd_last_o
);
  localparam logic [CODE_W-1:0] LAST_BIN = '1;

  hist_st_e          st_q;
  logic [CODE_W-1:0] clr_addr_q;
  logic              start_ok, rd_go, acc, rd_done;
  logic              seen_q;

  logic              ram_we;
  logic [CODE_W-1:0] ram_waddr, ram_raddr;
  logic [CNT_W-1:0]  ram_wdata, ram_rdata;

  logic              rmw_we, rmw_sat, rmw_upd;
  logic [CODE_W-1:0] rmw_waddr, rmw_code;
  logic [CNT_W-1:0]  rmw_wdata;
  logic [CODE_W-1:0] rd_raddr;

  assign start_ok = start_i && ((st_q == ST_IDLE) || (st_q == ST_COLLECT));
  assign rd_go    = read_i && !start_i && (st_q == ST_IDLE);
  assign acc      = smp_vld_i && !start_i && !stop_i && (st_q == ST_COLLECT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      clr_addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_ok) begin
            st_q       <= ST_CLEAR;
            clr_addr_q <= '0;
          end else if (rd_go) begin
            st_q <= ST_READ;
          end
        end
        ST_CLEAR: begin
          clr_addr_q <= clr_addr_q + 1'b1;
          if (clr_addr_q == LAST_BIN) st_q <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (start_ok) begin
            st_q       <= ST_CLEAR;
            clr_addr_q <= '0;
          end else if (stop_i) begin
            st_q <= ST_IDLE;
          end
        end
        ST_READ: if (rd_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // run statistics; a start overrides a late pipeline update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_o  <= '0;
      ovf_o    <= 1'b0;
      seen_q   <= 1'b0;
      lo_bin_o <= '1;
      hi_bin_o <= '0;
    end else if (start_ok) begin
      total_o  <= '0;
      ovf_o    <= 1'b0;
      seen_q   <= 1'b0;
      lo_bin_o <= '1;
      hi_bin_o <= '0;
    end else if (rmw_upd) begin
      total_o <= total_o + 1'b1;
      seen_q  <= 1'b1;
      if (rmw_sat) ovf_o <= 1'b1;
      if (rmw_code < lo_bin_o) lo_bin_o <= rmw_code;
      if (rmw_code > hi_bin_o) hi_bin_o <= rmw_code;
    end
  end

  assign busy_o      = (st_q == ST_CLEAR);
  assign range_vld_o = seen_q && ((st_q == ST_IDLE) || (st_q == ST_READ));

  assign ram_we    = busy_o || rmw_we;
  assign ram_waddr = busy_o ? clr_addr_q : rmw_waddr;
  assign ram_wdata = busy_o ? '0 : rmw_wdata;
  assign ram_raddr = (st_q == ST_READ) ? rd_raddr : smp_code_i;

  hist_ram #(
    .AW (CODE_W),
    .DW (CNT_W)
  ) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  hist_rmw #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
  ) u_rmw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .code_i     (smp_code_i),
    .rdata_i    (ram_rdata),
    .we_o       (rmw_we),
    .waddr_o    (rmw_waddr),
    .wdata_o    (rmw_wdata),
    .sat_o      (rmw_sat),
    .upd_o      (rmw_upd),
    .upd_code_o (rmw_code)
  );

  hist_reader #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W),
    .TOT_W  (TOT_W)
  ) u_reader (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (rd_go),
    .rdata_i   (ram_rdata),
    .raddr_o   (rd_raddr),
    .done_o    (rd_done),
    .rd_vld_o  (rd_vld_o),
    .rd_rdy_i  (rd_rdy_i),
    .rd_bin_o  (rd_bin_o),
    .rd_cnt_o  (rd_cnt_o),
    .rd_cum_o  (rd_cum_o),
    .rd_last_o (rd_last_o)
  );

  // R1
  clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rmw_we);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovf_o) && !$past(start_ok)) |-> ovf_o);
  // R4
  total_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_ok) |-> ((total_o == $past(total_o)) ||
                          (total_o == $past(total_o) + 1'b1)));
  // R6
  range_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_vld_o |-> (lo_bin_o <= hi_bin_o));
  // R7
  read_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> (st_q == ST_READ));
endmodule

// File: tb/tb_adc_code_hist.sv
`timescale 1ns/1ps
module tb_adc_code_hist;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 6;
  localparam int TOT_W  = 16;
  localparam int NB     = 1 << CODE_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0, stop_i = 1'b0, read_i = 1'b0;
  logic              smp_vld_i = 1'b0;
  logic [CODE_W-1:0] smp_code_i = '0;
  logic              busy_o, ovf_o, range_vld_o;
  logic [TOT_W-1:0]  total_o;
  logic [CODE_W-1:0] lo_bin_o, hi_bin_o;
  logic              rd_vld_o, rd_rdy_i = 1'b0;
  logic [CODE_W-1:0] rd_bin_o;
  logic [CNT_W-1:0]  rd_cnt_o;
  logic [TOT_W-1:0]  rd_cum_o;
  logic              rd_last_o;

  always #2.5 clk_i = ~clk_i;

  adc_code_hist #(.CODE_W(CODE_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .read_i(read_i), .smp_vld_i(smp_vld_i), .smp_code_i(smp_code_i),
    .busy_o(busy_o), .ovf_o(ovf_o), .total_o(total_o),
    .range_vld_o(range_vld_o), .lo_bin_o(lo_bin_o), .hi_bin_o(hi_bin_o),
    .rd_vld_o(rd_vld_o), .rd_rdy_i(rd_rdy_i), .rd_bin_o(rd_bin_o),
    .rd_cnt_o(rd_cnt_o), .rd_cum_o(rd_cum_o), .rd_last_o(rd_last_o));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int exp_h [NB];
  int tot_m, lo_m, hi_m;
  bit ovf_m, coll;

  function automatic int sat_cnt(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) exp_h[i] = 0;
    tot_m = 0; lo_m = NB; hi_m = -1; ovf_m = 1'b0;
  endtask

  task automatic drive(bit v, int code);
    smp_vld_i  = v;
    smp_code_i = CODE_W'(code);
    if (v && coll) begin
      if (exp_h[code] >= CMAX) ovf_m = 1'b1;
      exp_h[code]++;
      tot_m++;
      if (code < lo_m) lo_m = code;
      if (code > hi_m) hi_m = code;
    end
    @(negedge clk_i);
    smp_vld_i = 1'b0;
  endtask

  task automatic do_start(bit noise);
    int n = 0;
    start_i = 1'b1;
    if (noise) smp_vld_i = 1'b1;  // same-cycle sample must be dropped
    @(negedge clk_i);
    start_i = 1'b0;
    smp_vld_i = 1'b0;
    model_reset();
    chk(range_vld_o == 1'b0, "R6", "range_vld during clear", range_vld_o, 0);
    while (busy_o && n < 4 * NB) begin
      smp_vld_i  = noise;
      smp_code_i = CODE_W'($urandom % NB);
      @(negedge clk_i);
      n++;
    end
    smp_vld_i = 1'b0;
    chk(n == NB, "R1", "busy cycles", n, NB);
    coll = 1'b1;
  endtask

  task automatic do_stop();
    coll = 1'b0;
    stop_i = 1'b1;
    smp_vld_i = 1'b1;  // ignored: same cycle as stop
    @(negedge clk_i);
    stop_i = 1'b0;
    smp_vld_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic check_stats(string tag);
    chk(total_o == TOT_W'(tot_m), "R4", {tag, " total"}, total_o, tot_m);
    chk(ovf_o == ovf_m, "R5", {tag, " ovf"}, ovf_o, ovf_m);
    chk(range_vld_o == (tot_m > 0), "R6", {tag, " range_vld"}, range_vld_o, tot_m > 0);
    if (tot_m > 0) begin
      chk(lo_bin_o == CODE_W'(lo_m), "R6", {tag, " lo_bin"}, lo_bin_o, lo_m);
      chk(hi_bin_o == CODE_W'(hi_m), "R6", {tag, " hi_bin"}, hi_bin_o, hi_m);
    end
  endtask

  task automatic do_read(string tag, bit noise);
    int idx = 0, guard = 0;
    longint cum = 0;
    bit stalled = 1'b0;
    logic [CODE_W-1:0] s_bin;
    logic [CNT_W-1:0]  s_cnt;
    logic [TOT_W-1:0]  s_cum;
    read_i = 1'b1;
    @(negedge clk_i);
    read_i = 1'b0;
    while (idx < NB && guard < 100 * NB) begin
      guard++;
      if (stalled) begin
        chk(rd_vld_o && rd_bin_o == s_bin && rd_cnt_o == s_cnt && rd_cum_o == s_cum,
            "R9", {tag, " beat held"}, rd_cum_o, s_cum);
      end
      rd_rdy_i   = ($urandom % 3) != 0;
      smp_vld_i  = noise && ($urandom % 2 == 0);
      smp_code_i = CODE_W'($urandom % NB);
      stalled = rd_vld_o && !rd_rdy_i;
      s_bin = rd_bin_o; s_cnt = rd_cnt_o; s_cum = rd_cum_o;
      if (rd_vld_o && rd_rdy_i) begin
        cum += sat_cnt(exp_h[idx]);
        chk(rd_bin_o == CODE_W'(idx), "R7", {tag, " bin index"}, rd_bin_o, idx);
        chk(rd_cnt_o == CNT_W'(sat_cnt(exp_h[idx])), "R3", {tag, " bin count"},
            rd_cnt_o, sat_cnt(exp_h[idx]));
        chk(rd_cum_o == TOT_W'(cum), "R8", {tag, " cumulative"}, rd_cum_o, cum);
        chk(rd_last_o == (idx == NB - 1), "R8", {tag, " last flag"}, rd_last_o, idx == NB - 1);
        if (idx == NB - 1 && !ovf_m)
          chk(rd_cum_o == total_o, "R8", {tag, " final cum vs total"}, rd_cum_o, total_o);
        idx++;
      end
      @(negedge clk_i);
    end
    rd_rdy_i = 1'b0;
    smp_vld_i = 1'b0;
    chk(idx == NB, "R7", {tag, " beats seen"}, idx, NB);
    @(negedge clk_i);
    chk(rd_vld_o == 1'b0, "R7", {tag, " stream ends"}, rd_vld_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    coll = 1'b0;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 0, "R1", "reset busy", busy_o, 0);
    chk(ovf_o == 0, "R1", "reset ovf", ovf_o, 0);
    chk(total_o == 0, "R1", "reset total", total_o, 0);
    chk(range_vld_o == 0, "R1", "reset range_vld", range_vld_o, 0);
    chk(rd_vld_o == 0, "R1", "reset rd_vld", rd_vld_o, 0);
    // R2 samples before any start are dropped
    for (int i = 0; i < 5; i++) drive(1'b1, 4);

    // phase A: random band plus directed bursts
    do_start(1'b1);
    chk(range_vld_o == 0, "R6", "range_vld while collecting", range_vld_o, 0);
    read_i = 1'b1;
    @(negedge clk_i);
    read_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(rd_vld_o == 0, "R7", "read during collect ignored", rd_vld_o, 0);
      @(negedge clk_i);
    end
    for (int i = 0; i < 300; i++) drive(($urandom % 4) != 0, 3 + ($urandom % 9));
    for (int i = 0; i < 6; i++) drive(1'b1, 7);   // R3 back-to-back same bin
    drive(1'b1, 2);
    drive(1'b1, 2);
    drive(1'b1, 13);
    drive(1'b0, 0);
    drive(1'b1, 13);
    drive(1'b1, 7);
    drive(1'b1, 13);
    @(negedge clk_i);
    chk(total_o == TOT_W'(tot_m), "R4", "total while collecting", total_o, tot_m);
    do_stop();
    check_stats("A");
    for (int i = 0; i < 5; i++) drive(1'b1, 9);   // R2 after stop
    check_stats("A after stop");
    do_read("A", 1'b0);
    do_read("A noisy", 1'b1);                     // R2 samples during readout
    check_stats("A after read");

    // phase B: saturation
    do_start(1'b0);
    for (int i = 0; i < CMAX + 7; i++) drive(1'b1, 5);
    drive(1'b1, 9);
    drive(1'b0, 0);
    drive(1'b1, 9);
    drive(1'b1, 9);
    do_stop();
    chk(ovf_o == 1, "R5", "ovf set on saturation", ovf_o, 1);
    check_stats("B");
    do_read("B", 1'b0);
    chk(ovf_o == 1, "R5", "ovf sticky after read", ovf_o, 1);

    // phase C: empty run
    do_start(1'b0);
    chk(ovf_o == 0, "R5", "ovf cleared by start", ovf_o, 0);
    chk(total_o == 0, "R1", "total cleared by start", total_o, 0);
    do_stop();
    check_stats("C");
    do_read("C", 1'b0);

    // phase D: full code range, restart mid-run
    do_start(1'b0);
    for (int i = 0; i < 40; i++) drive(1'b1, $urandom % NB);
    do_start(1'b1);
    for (int i = 0; i < 250; i++) drive(($urandom % 3) != 0, $urandom % NB);
    drive(1'b1, 0);
    drive(1'b1, NB - 1);
    do_stop();
    check_stats("D");
    do_read("D", 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule